// File: doc/BRIEF.md
# Charger Emulation Interrupt and Status Aggregator

This block gathers the condition signals produced by a USB charger-emulation controller and presents them to a register file as three bytes. The status byte shows the live state of the conditions. The interrupt byte latches events. The mask byte chooses which events may latch. Five of the conditions are level inputs, and an event is their rising edge. The other two events are the start and the end of a supply-toggle cycle, which arrive as single-cycle pulses. A small state machine turns those pulses into a toggle-finished level, and the status byte reports that level.

An active-low interrupt pin, modelled as the pull-down control of an open-drain driver, goes low while any latched event is pending and a global enable input is high. The enable bit sits in another register, which the register file owns. Software reads the interrupt byte to learn which events occurred, and the read clears it. Reading the status byte does not clear anything. The mask is a write-only byte.

Top module: `chg_irq_aggregator`

Byte layout, shared by the interrupt, status and mask bytes:

| Bit | Source | Interrupt byte | Status byte |
|-----|--------|----------------|-------------|
| 7 | `cond_lvl[4]`, CDP device detected | rising edge | live level |
| 6 | `cond_lvl[3]`, CDP handshake bypassed | rising edge | live level |
| 5 | `cond_lvl[2]`, CDP connect check in progress | rising edge | live level |
| 4 | reserved | always 0 | always 0 |
| 3 | `cond_lvl[1]`, USB data session in pass-through-with-CDP mode | rising edge | live level |
| 2 | `cond_lvl[0]`, remote wake-up | rising edge | live level |
| 1 | toggle start | `tog_start` pulse | reserved, reads 0 |
| 0 | toggle stop | `tog_stop` pulse | toggle-finished level |

Toggle state machine:

| State | Toggle-finished level | Meaning |
|-------|-----------------------|---------|
| TOG_POR | 0 | reset state |
| TOG_RUN | 0 | a toggle is under way |
| TOG_DONE | 1 | the last toggle has finished |

Transitions:
- `tog_stop` moves any state to TOG_DONE.
- `tog_start` without `tog_stop` moves any state to TOG_RUN.
- A start and a stop in the same cycle end in TOG_DONE.
- With neither pulse, the state holds.

## Requirements
- R1: After reset the interrupt byte, the status byte and the mask all read as 0x00. Every source is masked, and `irq_n` is high.
- R2: A rising edge on a condition level whose mask bit is 1 sets its interrupt bit at the next clock edge. The bit mapping is given in the layout table above. A level that stays high does not set its bit again after a clear.
- R3: An event whose mask bit is 0 at the clock edge where it occurs is not latched. Setting the mask bit afterwards does not recover it.
- R4: A `tog_start` pulse sets interrupt bit 1 and a `tog_stop` pulse sets interrupt bit 0, each only when its mask bit is 1. Interrupt bit 4 never reads 1, whatever the mask.
- R5: Status bits 7, 6, 5, 3 and 2 show the live condition levels. Status bits 4 and 1 read 0. Status bit 0 reads 1 only in TOG_DONE. It is 0 after reset and 0 after a start. It is 1 after a stop, and also after a start and a stop in the same cycle.
- R6: Reading the interrupt byte (`rd_stb` with `rd_sel`=0) returns the pending bits and clears them. An event that lands in the same cycle as the read is not returned by that read and stays pending.
- R7: `irq_n` is low exactly when `irq_en` is 1 and at least one interrupt bit is pending. While `irq_en` is 0 the pin stays high, and pending bits are kept.
- R8: A mask write (`wr_stb`) takes effect from the cycle after the write. An event in the same cycle as the write uses the old mask.
- R9: Reading the status byte (`rd_stb` with `rd_sel`=1) leaves the interrupt byte unchanged.
- R10: `rd_data` updates one clock edge after a read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_lvl | input | 5 | Condition levels; see the layout table for the mapping |
| tog_start | input | 1 | Single-cycle pulse when a supply toggle begins |
| tog_stop | input | 1 | Single-cycle pulse when a supply toggle ends |
| irq_en | input | 1 | Global interrupt enable for the pin |
| rd_stb | input | 1 | Read strobe |
| rd_sel | input | 1 | Read select: 0 = interrupt byte (read clears it), 1 = status byte |
| wr_stb | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask value to write |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt pin pull-down control, active low |

## Verification
The hardest cases to reach are those where two actions meet on one clock edge. One is an event arriving in the same cycle as the clearing read. Another is an event arriving in the same cycle as a mask write. The third is a toggle start and stop pulsed together. The bench drives each pair on the same negative clock edge, so that both are sampled by a single rising edge. It then reads the interrupt byte twice, to tell what the first read returned from what stayed pending. A sweep over all 256 mask values fires every source at once and checks both the latched byte and the pin.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_LVL  = 5;
    localparam int POS_STOP = 0;
    localparam int POS_STRT = 1;
    localparam int POS_RSVD = 4;

    typedef enum logic [1:0] {
        TOG_POR  = 2'd0,
        TOG_RUN  = 2'd1,
        TOG_DONE = 2'd2
    } tog_state_e;

    // Byte position of condition level i
    function automatic int lvl_pos(input int i);
        case (i)
            0:       return 2;
            1:       return 3;
            2:       return 5;
            3:       return 6;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/chg_irq_edge.sv
module chg_irq_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end

    // R2: a level must fall before it can rise again
    a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rise & $past(rise)) == '0);

endmodule

// File: rtl/chg_irq_toggle.sv
module chg_irq_toggle
    import chg_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic done
);
    tog_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TOG_POR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOG_POR, TOG_RUN, TOG_DONE: begin
                if (stop)       state_d = TOG_DONE;
                else if (start) state_d = TOG_RUN;
            end
            default: state_d = TOG_POR;
        endcase
    end

    always_comb begin
        done = (state_q == TOG_DONE);
    end

    a_r5_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> done);
    a_r5_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> !done);
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !stop) |=> $stable(done));

endmodule

// File: rtl/chg_irq_latch.sv
module chg_irq_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] mask,
    input  logic         clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (clr ? '0 : pend_q) | (ev & mask);
    end
    assign pend = pend_q;

    // R3: newly set bits had their mask open on the previous edge
    a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q)) & ~$past(mask)) == '0);
    // R2: newly set bits come from an event
    a_r2_event_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q)) & ~$past(ev)) == '0);
    // R6: a clear with no event empties the byte
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev == '0) |=> pend_q == '0);

endmodule

// File: rtl/chg_irq_aggregator.sv
module chg_irq_aggregator
    import chg_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_LVL-1:0] cond_lvl,
    input  logic             tog_start,
    input  logic             tog_stop,
    input  logic             irq_en,
    input  logic             rd_stb,
    input  logic             rd_sel,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_n
);
    localparam logic [REG_W-1:0] RSVD_MASK = REG_W'(1) << POS_RSVD;

    logic [NUM_LVL-1:0] rise;
    logic               tog_done;
    logic [REG_W-1:0]   ev_vec, stat_vec, mask_q, pend, rd_q;
    logic               clr_irq;

    chg_irq_edge #(.W(NUM_LVL)) u_edge (
        .clk (clk), .rst_n (rst_n), .lvl (cond_lvl), .rise (rise)
    );

    chg_irq_toggle u_tog (
        .clk (clk), .rst_n (rst_n), .start (tog_start), .stop (tog_stop),
        .done (tog_done)
    );

    // Place level-derived bits into byte positions
    always_comb begin
        ev_vec   = '0;
        stat_vec = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            ev_vec[lvl_pos(i)]   = rise[i];
            stat_vec[lvl_pos(i)] = cond_lvl[i];
        end
        ev_vec[POS_STRT]   = tog_start;
        ev_vec[POS_STOP]   = tog_stop;
        stat_vec[POS_STOP] = tog_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= '0;
        else if (wr_stb) mask_q <= wr_data & ~RSVD_MASK;
    end

    assign clr_irq = rd_stb && !rd_sel;

    chg_irq_latch #(.W(REG_W)) u_latch (
        .clk (clk), .rst_n (rst_n), .ev (ev_vec), .mask (mask_q),
        .clr (clr_irq), .pend (pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_stb) rd_q <= rd_sel ? stat_vec : pend;
    end

    assign rd_data = rd_q;
    assign irq_n   = !(irq_en && (pend != '0));

    a_r7_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    a_r4_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[POS_RSVD]);
    a_r9_stat_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_sel) |=> (pend & $past(pend)) == $past(pend));

endmodule

// File: tb/chg_irq_aggregator_test.sv
module chg_irq_aggregator_test;
    logic       clk = 0, rst_n = 0;
    logic [4:0] cond_lvl = '0;
    logic       tog_start = 0, tog_stop = 0, irq_en = 0;
    logic       rd_stb = 0, rd_sel = 0, wr_stb = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    chg_irq_aggregator uut (.*);

    function automatic logic [7:0] place(input logic [4:0] l);
        return {l[4], l[3], l[2], 1'b0, l[1], l[0], 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_stb = 1; rd_sel = sel; step(); rd_stb = 0; v = rd_data;
    endtask

    task automatic wmask(input logic [7:0] m);
        wr_stb = 1; wr_data = m; step(); wr_stb = 0;
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, hold;
        @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        // R1 reset state
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        rd(0, v); chk("R1 irq byte", v, 8'h00);
        rd(1, v); chk("R1 status byte", v, 8'h00);
        cond_lvl = 5'h1F; tog_start = 1; step(); cond_lvl = 0; tog_start = 0;
        rd(0, v); chk("R1 mask blocks all", v, 8'h00);

        // R2/R4/R7 sweep over every mask value
        for (int m = 0; m < 256; m++) begin
            wmask(8'(m));
            rd(0, v);
            irq_en = m[0] ^ m[7];
            cond_lvl = 5'h1F; tog_start = 1; tog_stop = 1; step();
            cond_lvl = 0; tog_start = 0; tog_stop = 0;
            chk("R7 pin", {7'd0, irq_n},
                {7'd0, !(irq_en && ((8'(m) & 8'hEF) != 0))});
            rd(0, v); chk("R2 R4 sweep", v, 8'(m) & 8'hEF);
        end
        irq_en = 0;

        // R2 per-level mapping
        wmask(8'hFF);
        for (int i = 0; i < 5; i++) begin
            cond_lvl = 5'(1 << i); step();
            rd(0, v); chk("R2 mapping", v, place(5'(1 << i)));
            step(); step();
            rd(0, v); chk("R2 held level no re-set", v, 8'h00);
            cond_lvl = 0; step();
        end

        // R5 status levels sweep (toggle done from last sweep step)
        for (int l = 0; l < 32; l++) begin
            cond_lvl = 5'(l); step();
            rd(1, v); chk("R5 status", v, place(5'(l)) | 8'h01);
        end
        cond_lvl = 0; step(); rd(0, v);
        tog_start = 1; step(); tog_start = 0;
        rd(1, v); chk("R5 start clears done", v, 8'h00);
        tog_stop = 1; step(); tog_stop = 0;
        rd(1, v); chk("R5 stop sets done", v, 8'h01);
        rd(0, v); chk("R4 start then stop bits", v, 8'h03);

        // R6 event on the read cycle
        cond_lvl = 5'h01; step();
        rd_stb = 1; rd_sel = 0; cond_lvl = 5'h03; step(); rd_stb = 0;
        chk("R6 read returns old", rd_data, 8'h04);
        rd(0, v); chk("R6 event kept", v, 8'h08);
        cond_lvl = 0; step();

        // R9 status read keeps pending
        tog_stop = 1; step(); tog_stop = 0;
        rd(1, v); rd(0, v); chk("R9 status read no clear", v, 8'h01);

        // R7 enable off keeps pending, pin released
        tog_start = 1; step(); tog_start = 0;
        irq_en = 0; step();
        chk("R7 disabled pin high", {7'd0, irq_n}, 8'h01);
        irq_en = 1; step();
        chk("R7 enabled pin low", {7'd0, irq_n}, 8'h00);
        rd(0, v); chk("R7 pending kept", v, 8'h02);
        chk("R7 pin released after clear", {7'd0, irq_n}, 8'h01);
        irq_en = 0;

        // R3 masked event not recovered
        wmask(8'h00);
        cond_lvl = 5'h10; step();
        wmask(8'hFF); step();
        rd(0, v); chk("R3 masked lost", v, 8'h00);
        cond_lvl = 0; step();

        // R8 write in same cycle as event uses old mask
        wmask(8'h00);
        wr_stb = 1; wr_data = 8'hFF; cond_lvl = 5'h08; step(); wr_stb = 0;
        rd(0, v); chk("R8 old mask at write", v, 8'h00);
        cond_lvl = 0; step(); cond_lvl = 5'h08; step();
        rd(0, v); chk("R8 new mask after", v, 8'h40);
        cond_lvl = 0;

        // R10 hold
        tog_stop = 1; step(); tog_stop = 0;
        rd(0, hold);
        cond_lvl = 5'h1F; step(); step(); cond_lvl = 0; step();
        chk("R10 rd_data hold", rd_data, hold);
        rd(0, v); chk("R10 next read", v, 8'hEC);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule